// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Controller

This block watches a set of input lines and turns selected edges on them into interrupt requests and event pulses. Each line can be armed for a rising edge, a falling edge, or both. An armed edge is caught by a flop that is clocked by the line itself, so a pulse much shorter than one bus clock period is still recorded. The captured flag is then carried into the bus clock domain through a two-flop synchronizer. A detected edge sets a sticky pending bit when the line's interrupt mask is open. It also produces a one-cycle event pulse when the line's event mask is open.

The low sixteen lines do not come from dedicated pins. Each one is taken from a selector that picks one of several GPIO ports at the same pin index. The remaining lines come from dedicated external inputs. Software configures the block through a small word-addressed register port. Pending bits are cleared by writing ones to them, and a software trigger register fires any line as though an edge had occurred. The block drives one interrupt bit per line and a single combined request.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, and `irq_o`, `irq_any` and `evt_o` are all low.
- R2: A line whose rise-enable bit (word 0) is set triggers on a low-to-high transition, and ignores a high-to-low transition when its fall-enable bit is clear.
- R3: A line whose fall-enable bit (word 1) is set triggers on a high-to-low transition, and ignores a low-to-high transition when its rise-enable bit is clear.
- R4: With both enable bits set, a line triggers on either transition.
- R5: A pulse lasting a quarter of a bus clock period is still detected. With both edges enabled, the two edges of such a pulse produce a single trigger.
- R6: A trigger sets the line's pending bit (word 5) only while its interrupt-mask bit (word 2) is 1. Otherwise the pending bit stays 0.
- R7: Each trigger produces exactly one single-cycle pulse on `evt_o` for that line while its event-mask bit (word 3) is 1, and no pulse while that bit is 0.
- R8: Writing 1 to a bit of word 5 clears that pending bit. Writing 0 leaves the bit unchanged.
- R9: Writing 1 to a bit of word 4 triggers that line exactly as an edge would, subject to both masks. Word 4 always reads back as zero.
- R10: Line i for i < 16 follows `gpio_in[p*16+i]`. Here p is a 3-bit port field held at bits [4*(i%8)+2 : 4*(i%8)] of word 8 + i/8. Pins of the ports that are not selected have no effect on the line.
- R11: `irq_o` equals the pending register, and `irq_any` is high exactly when some pending bit is set.
- R12: An edge that arrives between two clock edges sets the pending bit on the third rising clock edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Asynchronous active-high reset |
| gpio_in | input | NPORTS*NSEL | GPIO pins; port p, pin i at bit p*NSEL+i |
| ext_in | input | NLINES-NSEL | Dedicated lines NSEL and above |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| irq_o | output | NLINES | Per-line interrupt request (pending bits) |
| irq_any | output | 1 | OR of all pending bits |
| evt_o | output | NLINES | Per-line single-cycle event pulse |

## Verification
On every cycle, the assertions check how the synchronous state changes. A pending bit may rise only while its interrupt mask is open. A write-one clear removes a pending bit unless a trigger coincides with it. A software trigger on an unmasked line always lands in the pending register. An event pulse appears only when a trigger occurred and the event mask was open. Only the bench scenarios can show the behaviour of the asynchronous front end: edge polarity selection, capture of sub-period pulses, merging of both edges of a short pulse, the exact three-cycle latency, and the routing through the port selectors.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int NLINES = 23,
  parameter int NSEL   = 16,
  parameter int NPORTS = 8,
  parameter int AW     = 4,
  parameter int DW     = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPORTS*NSEL-1:0] gpio_in,
  input  logic [NLINES-NSEL-1:0] ext_in,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  output logic [NLINES-1:0]      irq_o,
  output logic                   irq_any,
  output logic [NLINES-1:0]      evt_o
);
  localparam int PW      = $clog2(NPORTS);
  localparam int SLOT    = 4;
  localparam int PER_REG = DW / SLOT;
  localparam int NSELREG = (NSEL + PER_REG - 1) / PER_REG;
  localparam logic [AW-1:0] A_RISE = AW'(0);
  localparam logic [AW-1:0] A_FALL = AW'(1);
  localparam logic [AW-1:0] A_IMSK = AW'(2);
  localparam logic [AW-1:0] A_EMSK = AW'(3);
  localparam logic [AW-1:0] A_SWT  = AW'(4);
  localparam logic [AW-1:0] A_PEND = AW'(5);
  localparam logic [AW-1:0] A_SEL  = AW'(8);

  logic [NLINES-1:0] rise_q, fall_q, imsk_q, emsk_q, pend_q, evt_q;
  logic [NLINES-1:0] s1_q, s2_q, s3_q, clr_q;
  logic [NLINES-1:0] line_w, cap_w, det, trig, wmask;
  logic [PW-1:0]     sel_q [NSEL];
  logic [NSELREG*DW-1:0] sel_pack;

  assign wmask = bus_wdata[NLINES-1:0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
      imsk_q <= '0;
      emsk_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_RISE) rise_q <= wmask;
      if (bus_addr == A_FALL) fall_q <= wmask;
      if (bus_addr == A_IMSK) imsk_q <= wmask;
      if (bus_addr == A_EMSK) emsk_q <= wmask;
    end
  end

  for (genvar j = 0; j < NSEL; j++) begin : g_sel
    logic [NPORTS-1:0] pinv;
    for (genvar p = 0; p < NPORTS; p++) begin : g_pin
      assign pinv[p] = gpio_in[p*NSEL + j];
    end
    always_ff @(posedge clk or posedge rst) begin
      if (rst) sel_q[j] <= '0;
      else if (bus_we && bus_addr == A_SEL + AW'(j / PER_REG))
        sel_q[j] <= bus_wdata[SLOT*(j % PER_REG) +: PW];
    end
    assign line_w[j] = pinv[sel_q[j]];
  end
  assign line_w[NLINES-1:NSEL] = ext_in;

  for (genvar j = 0; j < NLINES; j++) begin : g_cap
    logic cap_r, cap_f;
    always_ff @(posedge line_w[j] or posedge clr_q[j]) begin
      if (clr_q[j]) cap_r <= 1'b0;
      else          cap_r <= rise_q[j];
    end
    always_ff @(negedge line_w[j] or posedge clr_q[j]) begin
      if (clr_q[j]) cap_f <= 1'b0;
      else          cap_f <= fall_q[j];
    end
    assign cap_w[j] = cap_r | cap_f;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      s1_q  <= '0;
      s2_q  <= '0;
      s3_q  <= '0;
      clr_q <= '1;
    end else begin
      s1_q  <= cap_w;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      clr_q <= s2_q;
    end
  end

  assign det  = s2_q & ~s3_q;
  assign trig = det | ((bus_we && bus_addr == A_SWT) ? wmask : '0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pend_q <= '0;
      evt_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~((bus_we && bus_addr == A_PEND) ? wmask : '0))
              | (trig & imsk_q);
      evt_q  <= trig & emsk_q;
    end
  end

  assign irq_o   = pend_q;
  assign irq_any = |pend_q;
  assign evt_o   = evt_q;

  always_comb begin
    sel_pack = '0;
    for (int j = 0; j < NSEL; j++)
      sel_pack[j*SLOT +: SLOT] = SLOT'(sel_q[j]);
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RISE:  bus_rdata = DW'(rise_q);
      A_FALL:  bus_rdata = DW'(fall_q);
      A_IMSK:  bus_rdata = DW'(imsk_q);
      A_EMSK:  bus_rdata = DW'(emsk_q);
      A_PEND:  bus_rdata = DW'(pend_q);
      default: begin
        for (int k = 0; k < NSELREG; k++)
          if (bus_addr == A_SEL + AW'(k)) bus_rdata = sel_pack[k*DW +: DW];
      end
    endcase
  end
endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
  parameter int NLINES = 23,
  parameter int AW     = 4,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [NLINES-1:0] pend,
  input logic [NLINES-1:0] imsk,
  input logic [NLINES-1:0] emsk,
  input logic [NLINES-1:0] trig,
  input logic [NLINES-1:0] evt
);
  logic [NLINES-1:0] clr_w, sw_w;
  assign clr_w = (bus_we && bus_addr == AW'(5)) ? bus_wdata[NLINES-1:0] : '0;
  assign sw_w  = (bus_we && bus_addr == AW'(4)) ? bus_wdata[NLINES-1:0] : '0;

  AST_PEND_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(pend) & ~$past(imsk)) == '0); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (pend & $past(clr_w) & ~$past(trig)) == '0); // R8
  AST_SWTRIG_SETS: assert property (@(posedge clk) disable iff (rst)
    ($past(sw_w & imsk) & ~pend) == '0); // R9
  AST_EVT_GATED: assert property (@(posedge clk) disable iff (rst)
    (evt & ~$past(emsk)) == '0); // R7
  AST_EVT_CAUSED: assert property (@(posedge clk) disable iff (rst)
    (evt & ~$past(trig)) == '0); // R7
endmodule

bind edge_irq_ctrl edge_irq_chk #(.NLINES(NLINES), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pend(pend_q), .imsk(imsk_q), .emsk(emsk_q),
  .trig(trig), .evt(evt_q)
);

// File: tb/test_edge_irq_ctrl.sv
`timescale 1ns/1ps
module test_edge_irq_ctrl;
  localparam int NL = 23, NS = 16, NP = 8;

  logic clk = 0, rst = 1;
  logic [NP*NS-1:0] gpio_in = '0;
  logic [NL-NS-1:0] ext_in = '0;
  logic bus_we = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NL-1:0] irq_o, evt_o;
  logic irq_any;

  int compared = 0, mismatched = 0, mon_line = 0, evt_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  edge_irq_ctrl i_edge_irq_ctrl (
    .clk(clk), .rst(rst), .gpio_in(gpio_in), .ext_in(ext_in),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .irq_any(irq_any), .evt_o(evt_o)
  );

  always @(negedge clk) if (evt_o[mon_line]) evt_cnt++;

  typedef struct packed {
    logic [4:0] ln;
    logic [1:0] kind; // 0 rise, 1 fall, 2 short high pulse
    logic rs, fs, im, em, ep, ee;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{5'd16, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 rise armed
    '{5'd17, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 fall ignored
    '{5'd18, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R3 fall armed
    '{5'd19, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 rise ignored
    '{5'd20, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R4 both, rise
    '{5'd21, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R4 both, fall
    '{5'd22, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R5 short pulse
    '{5'd16, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R5 merged edges
    '{5'd17, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R6 imask closed
    '{5'd18, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}  // R7 emask closed
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(a[3:0], r);
      check("R1 register", r, 0);
    end
    check("R1 irq_o", 32'(irq_o), 0);
    check("R1 evt_o", 32'(evt_o), 0);
    check("R1 irq_any", 32'(irq_any), 0);

    for (int t = 0; t < 10; t++) begin
      vec_t v = TBL[t];
      int e = int'(v.ln) - NS;
      wr(0, 0); wr(1, 0);
      ext_in[e] = (v.kind == 2'd1);
      wait_cyc(8);
      wr(0, 32'(v.rs) << v.ln);
      wr(1, 32'(v.fs) << v.ln);
      wr(2, 32'(v.im) << v.ln);
      wr(3, 32'(v.em) << v.ln);
      wr(5, 32'hFFFF_FFFF);
      mon_line = int'(v.ln);
      evt_cnt = 0;
      @(negedge clk);
      if (v.kind == 2'd2) begin
        #0.5 ext_in[e] = 1;
        #1 ext_in[e] = 0;
      end else begin
        ext_in[e] = ~ext_in[e];
      end
      wait_cyc(10);
      rd(5, r);
      check($sformatf("table %0d pending", t), r, 32'(v.ep) << v.ln);
      check($sformatf("table %0d events", t), 32'(evt_cnt), 32'(v.ee));
    end

    // R12 latency
    wr(1, 0); wr(0, 0);
    ext_in = '0;
    wait_cyc(8);
    wr(0, 32'h1 << 16); wr(2, 32'h1 << 16); wr(5, 32'hFFFF_FFFF);
    @(negedge clk);
    ext_in[0] = 1;
    @(posedge clk); @(posedge clk); #1;
    check("R12 not yet pending", 32'(irq_o[16]), 0);
    @(posedge clk); #1;
    check("R12 pending on third edge", 32'(irq_o[16]), 1);

    // R10 selector routing
    wr(0, 0); wr(5, 32'hFFFF_FFFF);
    wr(8, 32'h0030_0000);
    rd(8, r);
    check("R10 selector readback", r, 32'h0030_0000);
    wr(0, 32'h1 << 5); wr(2, 32'h1 << 5); wr(5, 32'hFFFF_FFFF);
    gpio_in[0*16 + 5] = 1;
    wait_cyc(10);
    rd(5, r);
    check("R10 unselected port ignored", r, 0);
    gpio_in[3*16 + 5] = 1;
    wait_cyc(10);
    rd(5, r);
    check("R10 selected port triggers", r, 32'h1 << 5);
    check("R11 irq_o mirrors pending", 32'(irq_o), 32'h1 << 5);
    check("R11 irq_any high", 32'(irq_any), 1);

    // R8 write-one-to-clear
    wr(5, 0);
    rd(5, r);
    check("R8 zero write keeps pending", r, 32'h1 << 5);
    wr(5, 32'h1 << 5);
    rd(5, r);
    check("R8 one write clears", r, 0);
    check("R11 irq_any low", 32'(irq_any), 0);

    // R9 software trigger
    wr(2, 32'h1 << 3); wr(3, 32'h1 << 3);
    mon_line = 3;
    evt_cnt = 0;
    wr(4, (32'h1 << 3) | (32'h1 << 4));
    wait_cyc(3);
    rd(5, r);
    check("R9 swtrig pending, mask gates", r, 32'h1 << 3);
    check("R9 swtrig event once", 32'(evt_cnt), 1);
    rd(4, r);
    check("R9 swtrig reads zero", r, 0);

    done = 1;
    summary();
  end
endmodule